// File: doc/BRIEF.md
# Parallel Port Forward Byte Receiver

This block is the peripheral end of a byte-wide parallel printer port running forward transfers, from host to peripheral, in compatibility mode. The host puts a byte on an 8-line data bus and pulses an active-low strobe. The receiver resynchronises the bus and the strobe, and it checks that the data stayed steady for a set number of clock cycles before the strobe fell and after it rose. It then latches the byte on the rising strobe edge and writes it into a small internal buffer. Finally it answers with an active-low acknowledge pulse of fixed width.

The core reads received bytes through a valid/ready stream. `rx_valid_o` stays high while the buffer holds at least one byte. `rx_data_o` shows the oldest byte and does not change until the core takes it with `rx_ready_i` high on a clock edge. When the core holds `rx_ready_i` low, the buffer fills. Busy then stays high, which makes the host wait, and no byte is lost. The core also drives online, paper-out and fault levels. These appear on the select, paper-empty and busy lines. A change from offline to online produces one acknowledge pulse by itself.

Top module: `lpt_compat_rx`

## Requirements
- R1: `pd_i[7]` (line Data 8) is the most significant bit. A byte accepted from the bus appears unchanged on `rx_data_o`, with `rx_data_o[k]` equal to `pd_i[k]`.
- R2: A byte is discarded and the sticky flag `timing_err_o` is set in three cases: the synchronised bus changed fewer than SETUP_CYC cycles before the strobe fell, it changed while the strobe was low, or it changed within HOLD_CYC cycles after the strobe rose. A discarded byte is still acknowledged.
- R3: Each accepted strobe, whether or not its byte is discarded, produces exactly one `ack_n_o` low pulse lasting exactly ACK_CYC clock cycles.
- R4: A rising edge on `online_i` produces one `ack_n_o` pulse of ACK_CYC cycles and writes no byte.
- R5: `busy_o` is high while `fault_i` is high, while `online_i` is low, while the buffer is full, and from the detected strobe fall until the acknowledge pulse ends. Otherwise it is low.
- R6: `pe_o` follows `paper_out_i` and `slct_o` follows `online_i`, each one clock cycle later.
- R7: A strobe fall seen while `busy_o` is high is ignored. No byte is written and no acknowledge is given. The sticky flag `overrun_o` is set.
- R8: While `rx_valid_o` is high and `rx_ready_i` is low, `rx_valid_o` and `rx_data_o` hold. Bytes leave the buffer in arrival order, and a buffer of DEPTH entries holds DEPTH bytes.
- R9: After reset, `ack_n_o` is high, `rx_valid_o`, `overrun_o` and `timing_err_o` are low, and `busy_o` is high while `online_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_i | input | 8 | Parallel data bus, bit 7 is line Data 8 |
| strobe_n_i | input | 1 | Host data strobe, active low |
| online_i | input | 1 | Core reports peripheral online |
| paper_out_i | input | 1 | Core reports paper exhausted |
| fault_i | input | 1 | Core reports an error condition |
| ack_n_o | output | 1 | Acknowledge pulse to host, active low |
| busy_o | output | 1 | Busy to host |
| pe_o | output | 1 | Paper empty to host |
| slct_o | output | 1 | Select (online) to host |
| overrun_o | output | 1 | Sticky: strobe arrived while busy |
| timing_err_o | output | 1 | Sticky: setup or hold margin violated |
| rx_valid_o | output | 1 | Stream: a received byte is available |
| rx_data_o | output | 8 | Stream: oldest received byte |
| rx_ready_i | input | 1 | Stream: core takes the byte this cycle |

## Verification
The bench fills the buffer with the core stalled and then strobes once more. A design that overwrote a stored byte or still acknowledged that strobe would lose data or leave `overrun_o` low. It moves the bus one cycle before the strobe falls. A receiver without a setup check would deliver the wrong byte, and one that skipped the acknowledge for a rejected byte would leave the host waiting. It measures each acknowledge pulse, including the one caused by going online, so an off-by-one counter or a byte written on the online transition shows up. It also drains bytes with values asymmetric in their bits, so a reversed bit order or a misordered buffer is caught.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HOLD = 2'd2,
    ST_ACK  = 2'd3
  } hs_state_e;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {W{RST_VAL}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lpt_fifo.sv
module lpt_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign pop     = valid_o && ready_i;
  assign full_o  = (count == CW'(DEPTH));
  assign valid_o = (count != '0);
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_i) - CW'(pop);
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(rdata_o)));
endmodule

// File: rtl/lpt_handshake.sv
module lpt_handshake
  import lpt_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 25,
  parameter int HOLD_CYC  = 25,
  parameter int ACK_CYC   = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_n_s_i,
  input  logic [DW-1:0] dat_s_i,
  input  logic          online_i,
  input  logic          fault_i,
  input  logic          full_i,
  output logic          push_o,
  output logic [DW-1:0] wdata_o,
  output logic          ack_n_o,
  output logic          busy_o,
  output logic          overrun_o,
  output logic          timing_err_o
);
  localparam int SW   = $clog2(SETUP_CYC + 1);
  localparam int CMAX = (HOLD_CYC > ACK_CYC) ? HOLD_CYC : ACK_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  hs_state_e     state;
  logic          stb_prev, online_prev, pend, viol;
  logic [DW-1:0] dat_prev, byte_q;
  logic [SW-1:0] stable_cnt;
  logic [CW-1:0] cnt;
  logic          fall, rise, changed, blocked, hold_end, viol_now;

  assign fall     = stb_prev && !stb_n_s_i;
  assign rise     = !stb_prev && stb_n_s_i;
  assign changed  = (dat_s_i != dat_prev);
  assign blocked  = fault_i || !online_i || full_i;
  assign hold_end = (state == ST_HOLD) && (cnt == CW'(HOLD_CYC-1));
  assign viol_now = viol || changed;

  assign push_o  = hold_end && !viol_now;
  assign wdata_o = byte_q;
  assign ack_n_o = (state != ST_ACK);
  assign busy_o  = blocked || (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev     <= 1'b1;
      online_prev  <= 1'b0;
      dat_prev     <= '0;
      stable_cnt   <= '0;
      state        <= ST_IDLE;
      cnt          <= '0;
      byte_q       <= '0;
      viol         <= 1'b0;
      pend         <= 1'b0;
      overrun_o    <= 1'b0;
      timing_err_o <= 1'b0;
    end else begin
      stb_prev    <= stb_n_s_i;
      online_prev <= online_i;
      dat_prev    <= dat_s_i;
      if (changed) stable_cnt <= '0;
      else if (stable_cnt < SW'(SETUP_CYC)) stable_cnt <= stable_cnt + 1'b1;

      if (online_i && !online_prev) pend <= 1'b1;
      if (fall && (state != ST_IDLE || blocked)) overrun_o <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (fall && !blocked) begin
            state <= ST_LOW;
            viol  <= changed || (stable_cnt < SW'(SETUP_CYC));
          end else if (pend && online_i) begin
            state <= ST_ACK;
            cnt   <= '0;
            pend  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (changed) viol <= 1'b1;
          if (rise) begin
            byte_q <= dat_s_i;
            state  <= ST_HOLD;
            cnt    <= '0;
          end
        end
        ST_HOLD: begin
          if (changed) viol <= 1'b1;
          if (hold_end) begin
            if (viol_now) timing_err_o <= 1'b1;
            state <= ST_ACK;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (cnt == CW'(ACK_CYC-1)) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> busy_o);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  // R2
  terr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err_o |=> timing_err_o);
endmodule

// File: rtl/lpt_compat_rx.sv
module lpt_compat_rx #(
  parameter int DW        = 8,
  parameter int SYNC_STG  = 2,
  parameter int SETUP_CYC = 25,
  parameter int HOLD_CYC  = 25,
  parameter int ACK_CYC   = 250,
  parameter int DEPTH     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pd_i,
  input  logic          strobe_n_i,
  input  logic          online_i,
  input  logic          paper_out_i,
  input  logic          fault_i,
  output logic          ack_n_o,
  output logic          busy_o,
  output logic          pe_o,
  output logic          slct_o,
  output logic          overrun_o,
  output logic          timing_err_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  input  logic          rx_ready_i
);
  logic          stb_s;
  logic [DW-1:0] dat_s;
  logic          push, full;
  logic [DW-1:0] wdata;

  lpt_sync #(.W(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d_i(strobe_n_i), .q_o(stb_s));

  lpt_sync #(.W(DW), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d_i(pd_i), .q_o(dat_s));

  lpt_handshake #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .ACK_CYC(ACK_CYC)
  ) u_hs (
    .clk(clk), .rst_n(rst_n), .stb_n_s_i(stb_s), .dat_s_i(dat_s),
    .online_i(online_i), .fault_i(fault_i), .full_i(full),
    .push_o(push), .wdata_o(wdata), .ack_n_o(ack_n_o), .busy_o(busy_o),
    .overrun_o(overrun_o), .timing_err_o(timing_err_o));

  lpt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(wdata),
    .full_o(full), .valid_o(rx_valid_o), .ready_i(rx_ready_i),
    .rdata_o(rx_data_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_o   <= 1'b0;
      slct_o <= 1'b0;
    end else begin
      pe_o   <= paper_out_i;
      slct_o <= online_i;
    end
  end

  // R8
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: tb/lpt_compat_rx_tb.sv
module lpt_compat_rx_tb;
  localparam int SETUP = 25, HOLD = 25, ACKC = 250, DEPTH = 8;

  logic       clk = 0, rst_n = 0;
  logic [7:0] pd = 0;
  logic       stb_n = 1, online = 0, pout = 0, fault = 0, ready = 0;
  logic       ack_n, busy, pe, slct, ovr, terr, valid;
  logic [7:0] rdata;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  lpt_compat_rx #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .ACK_CYC(ACKC), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .strobe_n_i(stb_n), .online_i(online),
    .paper_out_i(pout), .fault_i(fault), .ack_n_o(ack_n), .busy_o(busy),
    .pe_o(pe), .slct_o(slct), .overrun_o(ovr), .timing_err_o(terr),
    .rx_valid_o(valid), .rx_data_o(rdata), .rx_ready_i(ready));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // wait up to lim cycles for an ack pulse, return its width (0 if none)
  task automatic meas_ack(input int lim, output int w);
    w = 0;
    for (int i = 0; i < lim && ack_n; i++) @(negedge clk);
    while (!ack_n) begin w++; @(negedge clk); end
  endtask

  task automatic send_byte(input logic [7:0] b, input int setup, output int w);
    pd = b;
    repeat (setup) @(negedge clk);
    stb_n = 0;
    repeat (10) @(negedge clk);
    total++;
    if (!busy) begin bad++; $display("FAIL R5: busy act=0 exp=1 during strobe"); end
    repeat (20) @(negedge clk);
    stb_n = 1;
    meas_ack(HOLD + 50, w);
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    chk(req, int'(valid), 1);
    chk(req, int'(rdata), int'(exp));
    ready = 1;
    @(negedge clk);
    ready = 0;
  endtask

  task automatic t_reset;
    chk("R9 ack_n", ack_n, 1);
    chk("R9 valid", valid, 0);
    chk("R9 overrun", ovr, 0);
    chk("R9 timing_err", terr, 0);
    chk("R9 busy offline", busy, 1);
  endtask

  task automatic t_online;
    int w;
    online = 1;
    meas_ack(20, w);
    chk("R4 online ack width", w, ACKC);
    chk("R4 no byte written", valid, 0);
    chk("R6 slct", slct, 1);
    chk("R5 busy idle", busy, 0);
  endtask

  task automatic t_bytes;
    int w;
    send_byte(8'hA5, 40, w);
    chk("R3 ack width", w, ACKC);
    send_byte(8'h81, 40, w);
    chk("R3 ack width 2", w, ACKC);
    repeat (5) @(negedge clk);
    chk("R8 hold data", int'(rdata), 8'hA5);
    pop_chk(8'hA5, "R8 order first");
    pop_chk(8'h81, "R1 msb byte");
    send_byte(8'h80, 40, w);
    pop_chk(8'h80, "R1 bit 7 is MSB");
    chk("R8 empty", valid, 0);
  endtask

  task automatic t_full;
    int w;
    for (int i = 0; i < DEPTH; i++) begin
      send_byte(8'(8'h10 + i * 7), 40, w);
      chk("R3 fill ack", w, ACKC);
    end
    chk("R5 busy full", busy, 1);
    pd = 8'hEE;
    repeat (40) @(negedge clk);
    stb_n = 0;
    repeat (20) @(negedge clk);
    stb_n = 1;
    meas_ack(400, w);
    chk("R7 no ack when busy", w, 0);
    chk("R7 overrun set", ovr, 1);
    for (int i = 0; i < DEPTH; i++) pop_chk(8'(8'h10 + i * 7), "R8 full drain order");
    chk("R7 rejected byte absent", valid, 0);
    chk("R5 busy after drain", busy, 0);
  endtask

  task automatic t_setup;
    int w;
    pd = 8'h11;
    repeat (40) @(negedge clk);
    send_byte(8'h22, 1, w);
    chk("R2 violated byte acked", w, ACKC);
    chk("R2 timing_err", terr, 1);
    chk("R2 byte discarded", valid, 0);
  endtask

  task automatic t_status;
    pout = 1; fault = 1;
    @(negedge clk); @(negedge clk);
    chk("R6 pe", pe, 1);
    chk("R5 busy fault", busy, 1);
    pout = 0; fault = 0; online = 0;
    @(negedge clk); @(negedge clk);
    chk("R6 pe low", pe, 0);
    chk("R6 slct low", slct, 0);
    chk("R5 busy offline", busy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_online();
    t_bytes();
    t_full();
    t_setup();
    t_status();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule